// File: doc/BRIEF.md
# Memory Chip-Select Decoder with Wait State

This block turns a 20-bit processor address and its bus strobes into active-low chip selects for a fixed memory map. The top 32 KB of the 1 MB space, F8000h to FFFFFh, holds read-only storage built from eight 4 KB devices. A gated 3-to-8 decode picks one of these devices from address bits 14..12. The bottom 512 KB, 00000h to 7FFFFh, holds RAM built from sixteen 32 KB devices, picked by address bits 18..15. The remaining addresses and every I/O cycle leave all selects inactive.

The read-only devices need 450 ns. The decode adds 12 ns. The bus cycle only allows 460 ns. Each wait state adds one 200 ns clock. The number of wait states for each region is computed from these timing parameters. With the default values, a read-only access gets one wait state and a RAM access gets none. The ready output is pulled low while wait states are owed and is released after that.

The selects are combinational on the bus inputs. Ready depends on one piece of state: whether a read-only access was already in progress in the previous clock.

Top module: `memsel_decoder`

## Requirements
- R1: A memory read (io_cycle_i=0, rd_ni=0) with address bits 19..15 all 1 drives rom_cs_no[addr[14:12]] low. All other bits of rom_cs_no stay high.
- R2: The read-only decode is gated by the read strobe. With rd_ni=1, rom_cs_no is all ones, even during a write to the read-only region.
- R3: A memory cycle with rd_ni=0 or wr_ni=0 and address bit 19 equal to 0 drives ram_cs_no[addr[18:15]] low. With both strobes high, ram_cs_no is all ones.
- R4: Addresses 80000h to F7FFFh assert no select.
- R5: During an I/O cycle (io_cycle_i=1), every select is high.
- R6: At most one bit across rom_cs_no and ram_cs_no is low at any time.
- R7: When a read-only access begins, ready_o goes low for exactly one clock. An access begins when it is active in a cycle where it was not active in the previous cycle. ready_o then returns high while the same access is held.
- R8: Ready stays high for RAM accesses, idle cycles, I/O cycles and addresses in the unmapped gap.
- R9: After reset, with an idle bus, all selects are high and ready_o is high.
- R10: The reset fetch address FFFF0h selects rom_cs_no[7].
- R11: Two read-only reads separated by a cycle with no read-only access each receive their own wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Processor address |
| io_cycle_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rom_cs_no | output | 8 | Read-only device selects, active low, index = addr[14:12] |
| ram_cs_no | output | 16 | RAM device selects, active low, index = addr[18:15] |
| ready_o | output | 1 | Low while a wait state is owed |

## Verification
The hardest case to reach from the ports is the wait-state timing. A long read-only access must not get a second wait state. A read that restarts after a single-cycle break must get a fresh one. To reach both, the random stimulus often repeats the previous bus cycle unchanged to hold an access across clocks, and often drops the read strobe for one cycle. Directed sequences also hold a read across several clocks, move it between devices without a break, and restart it after one idle cycle.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  // Wait states needed to cover an access time plus decode delay within a bus budget.
  function automatic int unsigned wait_states(int unsigned acc_ns, int unsigned dec_ns,
                                              int unsigned budget_ns, int unsigned wait_ns);
    int unsigned need;
    need = acc_ns + dec_ns;
    if (need <= budget_ns) return 0;
    return (need - budget_ns + wait_ns - 1) / wait_ns;
  endfunction

endpackage

// File: rtl/memsel_onehot_dec.sv
module memsel_onehot_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input  logic             g1_i,
  input  logic             g2a_ni,
  input  logic             g2b_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0] out_no
);
  logic en;
  assign en = g1_i & ~g2a_ni & ~g2b_ni;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign out_no[i] = ~(en && (sel_i == SEL_W'(i)));
  end
endmodule

// File: rtl/memsel_wait_gen.sv
module memsel_wait_gen #(
  parameter int unsigned WAIT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic ready_o
);
  if (WAIT == 0) begin : g_none
    logic unused_in;
    assign unused_in = clk_i ^ rst_ni ^ active_i;
    assign ready_o   = 1'b1;
  end else begin : g_cnt
    localparam int unsigned CW = (WAIT < 2) ? 1 : $clog2(WAIT + 1);
    logic          act_q;
    logic [CW-1:0] cnt_q;
    logic          start;

    assign start = active_i & ~act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        act_q <= active_i;
        if (start)                          cnt_q <= CW'(WAIT - 1);
        else if (active_i && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
        else if (!active_i)                 cnt_q <= '0;
      end
    end

    // low in the starting cycle and while owed cycles remain
    assign ready_o = ~(active_i & (start | (cnt_q != '0)));
  end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned ROM_DEV_AW = 12,
  parameter int unsigned ROM_SEL_W  = 3,
  parameter int unsigned RAM_DEV_AW = 15,
  parameter int unsigned RAM_SEL_W  = 4,
  parameter int unsigned ROM_ACC_NS = 450,
  parameter int unsigned RAM_ACC_NS = 10,
  parameter int unsigned DEC_NS     = 12,
  parameter int unsigned BUS_NS     = 460,
  parameter int unsigned WAIT_NS    = 200,
  localparam int unsigned ROM_N     = 1 << ROM_SEL_W,
  localparam int unsigned RAM_N     = 1 << RAM_SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_cycle_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic [ROM_N-1:0]  rom_cs_no,
  output logic [RAM_N-1:0]  ram_cs_no,
  output logic              ready_o
);
  import memsel_pkg::*;

  localparam int unsigned ROM_SEL_LO = ROM_DEV_AW;
  localparam int unsigned ROM_TAG_LO = ROM_DEV_AW + ROM_SEL_W;
  localparam int unsigned RAM_SEL_LO = RAM_DEV_AW;
  localparam int unsigned RAM_TAG_LO = RAM_DEV_AW + RAM_SEL_W;
  localparam int unsigned ROM_WAIT   = wait_states(ROM_ACC_NS, DEC_NS, BUS_NS, WAIT_NS);
  localparam int unsigned RAM_WAIT   = wait_states(RAM_ACC_NS, DEC_NS, BUS_NS, WAIT_NS);

  logic rom_tag_hit, ram_tag_hit;
  logic rom_act, ram_act;
  logic rom_rdy, ram_rdy;
  logic unused_low;

  assign rom_tag_hit = &addr_i[ADDR_W-1:ROM_TAG_LO];
  assign ram_tag_hit = ~|addr_i[ADDR_W-1:RAM_TAG_LO];
  assign unused_low  = ^addr_i[ROM_SEL_LO-1:0];

  memsel_onehot_dec #(.SEL_W(ROM_SEL_W)) u_rom_dec (
    .g1_i   (rom_tag_hit),
    .g2a_ni (io_cycle_i),
    .g2b_ni (rd_ni),
    .sel_i  (addr_i[ROM_TAG_LO-1:ROM_SEL_LO]),
    .out_no (rom_cs_no)
  );

  memsel_onehot_dec #(.SEL_W(RAM_SEL_W)) u_ram_dec (
    .g1_i   (ram_tag_hit),
    .g2a_ni (io_cycle_i),
    .g2b_ni (rd_ni & wr_ni),
    .sel_i  (addr_i[RAM_TAG_LO-1:RAM_SEL_LO]),
    .out_no (ram_cs_no)
  );

  assign rom_act = ~&rom_cs_no;
  assign ram_act = ~&ram_cs_no;

  memsel_wait_gen #(.WAIT(ROM_WAIT)) u_rom_wait (
    .clk_i, .rst_ni, .active_i(rom_act), .ready_o(rom_rdy)
  );

  memsel_wait_gen #(.WAIT(RAM_WAIT)) u_ram_wait (
    .clk_i, .rst_ni, .active_i(ram_act), .ready_o(ram_rdy)
  );

  assign ready_o = rom_rdy & ram_rdy;
endmodule

// File: rtl/memsel_checker.sv
module memsel_checker #(
  parameter int unsigned ROM_WAIT = 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [19:0] addr_i,
  input logic        io_cycle_i,
  input logic        rd_ni,
  input logic        wr_ni,
  input logic [7:0]  rom_cs_no,
  input logic [15:0] ram_cs_no,
  input logic        ready_o
);
  logic [7:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_run <= '0;
    else if (ready_o) low_run <= '0;
    else if (low_run != 8'hff) low_run <= low_run + 8'd1;
  end

  a_r6_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{rom_cs_no, ram_cs_no}));

  a_r5_io_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_cycle_i |-> (&rom_cs_no && &ram_cs_no));

  a_r2_rom_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> &rom_cs_no);

  a_r3_ram_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni && wr_ni) |-> &ram_cs_no);

  a_r4_gap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 20'h80000 && addr_i < 20'hF8000) |-> (&rom_cs_no && &ram_cs_no));

  a_r8_wait_only_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !(&rom_cs_no));

  a_r7_wait_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (low_run < ROM_WAIT));
endmodule

bind memsel_decoder memsel_checker #(.ROM_WAIT(ROM_WAIT)) u_memsel_checker (.*);

// File: tb/memsel_decoder_bench.sv
`timescale 1ns/1ps
module memsel_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr_i = '0;
  logic        io_cycle_i = 1'b0;
  logic        rd_ni = 1'b1;
  logic        wr_ni = 1'b1;
  logic [7:0]  rom_cs_no;
  logic [15:0] ram_cs_no;
  logic        ready_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          prev_rom = 1'b0;

  always #2 clk_i = ~clk_i;

  memsel_decoder u_memsel_decoder (.*);

  function automatic logic [7:0] exp_rom(logic [19:0] a, logic io, logic rdn);
    logic [7:0] v = 8'hff;
    if (!io && !rdn && a[19:15] == 5'b11111) v[a[14:12]] = 1'b0;
    return v;
  endfunction

  function automatic logic [15:0] exp_ram(logic [19:0] a, logic io, logic rdn, logic wrn);
    logic [15:0] v = 16'hffff;
    if (!io && (!rdn || !wrn) && !a[19]) v[a[18:15]] = 1'b0;
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check before the next posedge
  task automatic cyc(logic [19:0] a, logic io, logic rdn, logic wrn, string tag);
    logic [7:0]  er;
    logic [15:0] em;
    bit          rom_now;
    @(negedge clk_i);
    addr_i = a; io_cycle_i = io; rd_ni = rdn; wr_ni = wrn;
    #1;
    er = exp_rom(a, io, rdn);
    em = exp_ram(a, io, rdn, wrn);
    rom_now = (er != 8'hff);
    check({tag, " rom"}, 32'(rom_cs_no), 32'(er));
    check({tag, " ram"}, 32'(ram_cs_no), 32'(em));
    check({tag, rom_now ? " R7 ready" : " R8 ready"}, 32'(ready_o), 32'(!(rom_now && !prev_rom)));
    prev_rom = rom_now;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [19:0] a;
    logic io, rdn, wrn;
    void'($urandom(32'd20240611));
    #1;
    check("R9 reset rom", 32'(rom_cs_no), 32'hff);
    check("R9 reset ram", 32'(ram_cs_no), 32'hffff);
    check("R9 reset ready", 32'(ready_o), 32'h1);
    #10 rst_ni = 1'b1;
    cyc(20'h00000, 0, 1, 1, "R9 idle");

    // R10 reset fetch
    cyc(20'hFFFF0, 0, 0, 1, "R10 fetch");
    check("R10 dev7", 32'(rom_cs_no), 32'h7f);
    cyc(20'hFFFF0, 0, 1, 1, "R11 gap");
    // R1 every device, with idle between (R11 fresh waits)
    for (int d = 0; d < 8; d++) begin
      cyc(20'hF8000 | (20'(d) << 12) | 20'h0abc, 0, 0, 1, "R1 dev");
      cyc(20'h00000, 0, 1, 1, "R11 idle");
    end
    // R7 held access, then move between devices without a break
    cyc(20'hF9000, 0, 0, 1, "R7 start");
    cyc(20'hF9000, 0, 0, 1, "R7 hold1");
    cyc(20'hF9000, 0, 0, 1, "R7 hold2");
    cyc(20'hFA000, 0, 0, 1, "R7 switch");
    cyc(20'hFA000, 0, 1, 1, "R11 break");
    cyc(20'hFA000, 0, 0, 1, "R11 restart");
    // R2 writes to rom region
    cyc(20'hFC000, 0, 1, 0, "R2 write");
    // R3 RAM edges, R8 ready
    cyc(20'h00000, 0, 0, 1, "R3 ram0");
    cyc(20'h7FFFF, 0, 1, 0, "R3 ram15");
    cyc(20'h7FFFF, 0, 0, 1, "R8 ram hold");
    // R4 gap edges
    cyc(20'h80000, 0, 0, 1, "R4 lo");
    cyc(20'hF7FFF, 0, 0, 1, "R4 hi");
    // R5 io
    cyc(20'hFFFF0, 1, 0, 1, "R5 io rom");
    cyc(20'h12345, 1, 1, 0, "R5 io ram");

    a = '0; io = 0; rdn = 1; wrn = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 2) != 0) begin
        case ($urandom_range(0, 3))
          0: a = 20'hF8000 | 20'($urandom_range(0, 32'h7fff));
          1: a = 20'($urandom_range(0, 32'h7ffff));
          2: a = 20'h80000 + 20'($urandom_range(0, 32'h77fff));
          default: a = 20'($urandom);
        endcase
        io = ($urandom_range(0, 7) == 0);
        case ($urandom_range(0, 2))
          0: begin rdn = 0; wrn = 1; end
          1: begin rdn = 1; wrn = 0; end
          default: begin rdn = 1; wrn = 1; end
        endcase
      end
      cyc(a, io, rdn, wrn, "R6 random");
      check("R6 onehot", 32'($countones(~{rom_cs_no, ram_cs_no}) <= 1), 32'h1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule